// File: doc/BRIEF.md
# Multi-Image Boot Fallback Sequencer

This block decides which configuration image is fetched from an external flash after reset. It first issues a read of a small header at flash address 0x000000 and collects a three-byte, most-significant-first start address for the primary image. It then requests the primary image at that address. A watchdog measures the time from each image request until a downstream parser reports that the sync word was found. Once sync has been seen, the watchdog no longer applies, and the load ends either with a configuration-done indication or with a CRC-error strobe from a packet checker.

Two kinds of failure are handled differently. A watchdog expiry during the primary attempt always moves the read to the write-protected golden image at 0x010000. A CRC error after sync moves to the golden image only when the CRC-retry enable is high. With the enable low, the sequencer parks in a terminal failed state and leaves done low. This is what happens to a primary image whose header and sync word were written but whose tail was lost during a field update. The golden image gets a single attempt. Any failure of that attempt is terminal. Status flags stay set until the next reset.

Top module: `bootseq_top`

## Requirements
- R1: After reset is released, the first read request (`rd_start` high for exactly one cycle) carries address 0x000000. All status outputs are 0 while the header is being read.
- R2: The three header bytes, taken on cycles with `rd_valid` high, form the primary start address with the first byte as bits 23:16. The next read request uses that address.
- R3: A header of 0xFFFFFF (erased flash) selects the default primary address 0x600000.
- R4: When sync is seen within the window and `cfg_done` then arrives with no CRC error, `boot_done` goes high and `img_loaded` reads 1 (primary).
- R5: If `sync_seen` stays low for WDOG_CYC cycles after a primary read request, a read request at 0x010000 follows exactly WDOG_CYC+1 cycles after the primary request. `wdog_flag` and `fb_taken` are then set.
- R6: A `sync_seen` arriving on the last cycle of the watchdog window takes priority over the expiry, and no fallback occurs.
- R7: With `crc_reset_en` high, a `crc_err` strobe after sync on the primary image starts a read at 0x010000 and sets `crc_flag` and `fb_taken`.
- R8: With `crc_reset_en` low, a `crc_err` strobe after sync puts the block in the halted state. `boot_done` stays low, `fb_taken` stays 0 and no further read request is made.
- R9: A `crc_err` strobe while the block is still waiting for sync is ignored: it sets no flag and causes no fallback.
- R10: Any failure of the golden attempt (watchdog or CRC) ends in the halted state with `img_loaded` 0 and no further read request.
- R11: A successful golden load gives `img_loaded` = 2. `fb_taken`, `crc_flag`, `wdog_flag` and `img_loaded` hold their values until reset, and reset clears them.
- R12: After sync, a missing image tail never triggers the watchdog. Only `crc_err` or `cfg_done` ends the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_reset_en | input | 1 | Allows fallback after a CRC error on the primary image |
| rd_addr | output | 24 | Flash start address of the current read request |
| rd_start | output | 1 | One-cycle read request strobe |
| rd_valid | input | 1 | Header byte valid |
| rd_data | input | 8 | Header byte |
| sync_seen | input | 1 | Sync word detected in the current image |
| crc_err | input | 1 | CRC check failed strobe |
| cfg_done | input | 1 | Configuration finished |
| img_loaded | output | 2 | 0 none, 1 primary, 2 golden |
| boot_done | output | 1 | Image loaded successfully |
| halted | output | 1 | Terminal failure state |
| fb_taken | output | 1 | Sticky: fallback was started |
| crc_flag | output | 1 | Sticky: a CRC error ended an attempt |
| wdog_flag | output | 1 | Sticky: the watchdog ended an attempt |

## Verification
The primary load is tried with:
- a normal header and a clean load;
- an erased header;
- a missing sync word;
- sync arriving on the final watchdog cycle;
- a truncated image that sees sync and then goes silent, followed by a CRC strobe, with the retry enable both high and low;
- a golden image that also fails.

The missing-sync case and the late-sync case separate the two sides of the watchdog boundary. The truncated-image case separates a CRC failure from a watchdog failure. Running that case with the enable high and low separates fallback from the stuck failure. The measured gap between read requests pins the exact length of the watchdog window.

// File: rtl/bs_pkg.sv
// Shared types for the boot fallback sequencer.
// Assumes a single clock domain; no assumptions on flash timing.
package bs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR_REQ,
        ST_HDR_RD,
        ST_PRI_REQ,
        ST_GLD_REQ,
        ST_SYNC_WAIT,
        ST_LOAD,
        ST_BOOTED,
        ST_HALT
    } bs_state_e;

    localparam logic [1:0] IMG_NONE = 2'd0;
    localparam logic [1:0] IMG_PRI  = 2'd1;
    localparam logic [1:0] IMG_GLD  = 2'd2;
endpackage

// File: rtl/bs_hdr_parse.sv
// Collects the header bytes into the primary start address.
// Assumes bytes arrive first-is-most-significant. An all-ones header means
// erased flash and selects the default primary address.
module bs_hdr_parse #(
    parameter int          ADDR_W  = 24,
    parameter int          BYTE_W  = 8,
    parameter logic [23:0] DEF_PRI = 24'h600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              full,
    output logic [ADDR_W-1:0] pri_addr
);
    localparam int NBYTES = ADDR_W / BYTE_W;
    localparam int CNT_W  = $clog2(NBYTES + 1);

    logic [ADDR_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    assign full     = (cnt_q == CNT_W'(NBYTES));
    assign pri_addr = (&shreg_q) ? ADDR_W'(DEF_PRI) : shreg_q;

    // Shift in header bytes until the address is complete.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (take && !full) begin
            shreg_q <= {shreg_q[ADDR_W-BYTE_W-1:0], byte_in};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> $stable(shreg_q)); // R2
endmodule

// File: rtl/bs_wdog.sv
// Sync watchdog: counts cycles while waiting for sync and flags expiry
// on the WDOG_CYC-th waiting cycle. Cleared at each image request.
module bs_wdog #(
    parameter int WDOG_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int WD_W = (WDOG_CYC > 2) ? $clog2(WDOG_CYC) : 1;
    localparam logic [WD_W-1:0] LIM = WD_W'(WDOG_CYC - 1);

    logic [WD_W-1:0] cnt_q;

    assign expired = run && (cnt_q == LIM);

    // Count waiting cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM); // R5
endmodule

// File: rtl/bs_status.sv
// Sticky status flags and loaded-image code. Holds them until reset.
module bs_status
    import bs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_boot,
    input  logic       boot_gold,
    input  logic       ev_fb,
    input  logic       ev_crc,
    input  logic       ev_wdog,
    output logic [1:0] img,
    output logic       fb,
    output logic       crc,
    output logic       wdog
);
    logic [1:0] img_q;
    logic       fb_q, crc_q, wdog_q;

    assign img  = img_q;
    assign fb   = fb_q;
    assign crc  = crc_q;
    assign wdog = wdog_q;

    // Latch each event flag; record which image completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q  <= IMG_NONE;
            fb_q   <= 1'b0;
            crc_q  <= 1'b0;
            wdog_q <= 1'b0;
        end else begin
            if (ev_boot) img_q  <= boot_gold ? IMG_GLD : IMG_PRI;
            if (ev_fb)   fb_q   <= 1'b1;
            if (ev_crc)  crc_q  <= 1'b1;
            if (ev_wdog) wdog_q <= 1'b1;
        end
    end

    AST_FB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fb_q |=> fb_q); // R11
    AST_IMG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (img_q != IMG_NONE) |=> $stable(img_q)); // R11
endmodule

// File: rtl/bootseq_top.sv
// Boot fallback sequencer top: reads the header, requests the primary
// image, watches sync/CRC/done and falls back once to the golden image.
// Assumes crc_err and cfg_done are only meaningful after sync.
module bootseq_top
    import bs_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          BYTE_W    = 8,
    parameter logic [23:0] HDR_ADDR  = 24'h000000,
    parameter logic [23:0] DEF_PRI   = 24'h600000,
    parameter logic [23:0] GOLD_ADDR = 24'h010000,
    parameter int          WDOG_CYC  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crc_reset_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_start,
    input  logic              rd_valid,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              sync_seen,
    input  logic              crc_err,
    input  logic              cfg_done,
    output logic [1:0]        img_loaded,
    output logic              boot_done,
    output logic              halted,
    output logic              fb_taken,
    output logic              crc_flag,
    output logic              wdog_flag
);
    bs_state_e         state_q, state_d;
    logic              gold_q;
    logic              hdr_full;
    logic [ADDR_W-1:0] pri_addr;
    logic              wd_exp;
    logic              ev_boot, ev_fb, ev_crc, ev_wdog;

    bs_hdr_parse #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DEF_PRI(DEF_PRI)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == ST_HDR_REQ),
        .take     (state_q == ST_HDR_RD && rd_valid),
        .byte_in  (rd_data),
        .full     (hdr_full),
        .pri_addr (pri_addr)
    );

    bs_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rd_start),
        .run     (state_q == ST_SYNC_WAIT),
        .expired (wd_exp)
    );

    // Next-state logic; sync beats expiry, CRC beats done.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      state_d = ST_HDR_REQ;
            ST_HDR_REQ:   state_d = ST_HDR_RD;
            ST_HDR_RD:    if (hdr_full) state_d = ST_PRI_REQ;
            ST_PRI_REQ:   state_d = ST_SYNC_WAIT;
            ST_GLD_REQ:   state_d = ST_SYNC_WAIT;
            ST_SYNC_WAIT: begin
                if (sync_seen)   state_d = ST_LOAD;
                else if (wd_exp) state_d = gold_q ? ST_HALT : ST_GLD_REQ;
            end
            ST_LOAD: begin
                if (crc_err)       state_d = (!gold_q && crc_reset_en) ? ST_GLD_REQ : ST_HALT;
                else if (cfg_done) state_d = ST_BOOTED;
            end
            ST_BOOTED:    state_d = ST_BOOTED;
            ST_HALT:      state_d = ST_HALT;
            default:      state_d = ST_HALT;
        endcase
    end

    // State register and golden-attempt marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gold_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PRI_REQ) gold_q <= 1'b0;
            if (state_q == ST_GLD_REQ) gold_q <= 1'b1;
        end
    end

    // Read request strobe and its address.
    always_comb begin
        rd_start = 1'b0;
        rd_addr  = '0;
        case (state_q)
            ST_HDR_REQ: begin rd_start = 1'b1; rd_addr = ADDR_W'(HDR_ADDR);  end
            ST_PRI_REQ: begin rd_start = 1'b1; rd_addr = pri_addr;           end
            ST_GLD_REQ: begin rd_start = 1'b1; rd_addr = ADDR_W'(GOLD_ADDR); end
            default: ;
        endcase
    end

    // Event strobes for the status block.
    assign ev_wdog = (state_q == ST_SYNC_WAIT) && !sync_seen && wd_exp;
    assign ev_crc  = (state_q == ST_LOAD) && crc_err;
    assign ev_boot = (state_q == ST_LOAD) && !crc_err && cfg_done;
    assign ev_fb   = (state_d == ST_GLD_REQ) && (state_q != ST_GLD_REQ);

    bs_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_boot   (ev_boot),
        .boot_gold (gold_q),
        .ev_fb     (ev_fb),
        .ev_crc    (ev_crc),
        .ev_wdog   (ev_wdog),
        .img       (img_loaded),
        .fb        (fb_taken),
        .crc       (crc_flag),
        .wdog      (wdog_flag)
    );

    assign boot_done = (state_q == ST_BOOTED);
    assign halted    = (state_q == ST_HALT);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start); // R1
    AST_GOLD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && fb_taken) |-> (rd_addr == ADDR_W'(GOLD_ADDR))); // R7
    AST_CRC_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && crc_err && !crc_reset_en) |=> halted); // R8
    AST_HALT_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !rd_start && !boot_done)); // R10
    AST_PRE_SYNC_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC_WAIT && crc_err && !sync_seen && !wd_exp) |=> !crc_flag || $past(crc_flag)); // R9
endmodule

// File: tb/bootseq_top_bench.sv
// Scoreboard bench: scenario tasks queue expected read addresses, a
// monitor pops and compares them on each read request.
module bootseq_top_bench;
    localparam int W = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crc_reset_en = 1'b0;
    logic [23:0] rd_addr;
    logic        rd_start;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        sync_seen = 1'b0;
    logic        crc_err = 1'b0;
    logic        cfg_done = 1'b0;
    logic [1:0]  img_loaded;
    logic        boot_done, halted, fb_taken, crc_flag, wdog_flag;

    int errs = 0;
    int checks = 0;
    int n_starts = 0;
    int cyc = 0;
    int prev_cyc = 0;
    int last_gap = 0;
    logic [23:0] exp_q[$];

    always #2 clk = ~clk;

    bootseq_top u_bootseq_top (
        .clk(clk), .rst_n(rst_n), .crc_reset_en(crc_reset_en),
        .rd_addr(rd_addr), .rd_start(rd_start), .rd_valid(rd_valid),
        .rd_data(rd_data), .sync_seen(sync_seen), .crc_err(crc_err),
        .cfg_done(cfg_done), .img_loaded(img_loaded), .boot_done(boot_done),
        .halted(halted), .fb_taken(fb_taken), .crc_flag(crc_flag),
        .wdog_flag(wdog_flag)
    );

    // Monitor: compare every read request against the expected queue.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && rd_start) begin
            logic [23:0] e;
            n_starts++;
            last_gap = cyc - prev_cyc;
            prev_cyc = cyc;
            checks++;
            if (exp_q.size() == 0) begin
                errs++;
                $display("FAIL R10 unexpected read request actual=%h expected=none", rd_addr);
            end else begin
                e = exp_q.pop_front();
                if (rd_addr !== e) begin
                    errs++;
                    $display("FAIL R2 read address actual=%h expected=%h", rd_addr, e);
                end
            end
        end
        if (cyc == 150000) begin
            errs++;
            checks++;
            $display("FAIL R1 bench timeout actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_valid = 1'b0; sync_seen = 1'b0; crc_err = 1'b0; cfg_done = 1'b0;
        exp_q.delete();
        tick(3);
        n_starts = 0;
        rst_n = 1'b1;
    endtask

    task automatic wait_starts(input int n);
        while (n_starts < n) tick(1);
    endtask

    task automatic feed_hdr(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        wait_starts(1);
        rd_valid = 1'b1; rd_data = b0; tick(1);
        rd_data = b1; tick(1);
        rd_data = b2; tick(1);
        rd_valid = 1'b0;
    endtask

    task automatic pulse_sync();  sync_seen = 1'b1; tick(1); sync_seen = 1'b0; endtask
    task automatic pulse_crc();   crc_err = 1'b1;   tick(1); crc_err = 1'b0;   endtask
    task automatic pulse_done();  cfg_done = 1'b1;  tick(1); cfg_done = 1'b0;  endtask

    initial begin
        // S1: normal header, clean primary load
        do_reset();
        chk("R1 reset boot_done", int'(boot_done), 0);
        chk("R1 reset flags", int'({fb_taken, crc_flag, wdog_flag, halted}), 0);
        chk("R1 reset img_loaded", int'(img_loaded), 0);
        exp_q.push_back(24'h000000);
        exp_q.push_back(24'h123400);
        feed_hdr(8'h12, 8'h34, 8'h00);
        wait_starts(2);
        pulse_sync(); tick(2); pulse_done(); tick(2);
        chk("R4 boot_done", int'(boot_done), 1);
        chk("R4 img_loaded primary", int'(img_loaded), 1);
        chk("R2 starts issued", n_starts, 2);
        chk("R2 queue drained", exp_q.size(), 0);

        // S2: erased header, no sync -> golden, golden boots
        do_reset();
        exp_q.push_back(24'h000000);
        exp_q.push_back(24'h600000);
        exp_q.push_back(24'h010000);
        feed_hdr(8'hFF, 8'hFF, 8'hFF);
        wait_starts(3);
        chk("R3 queue drained", exp_q.size(), 0);
        chk("R5 watchdog gap", last_gap, W + 1);
        chk("R5 wdog_flag", int'(wdog_flag), 1);
        chk("R5 fb_taken", int'(fb_taken), 1);
        chk("R5 crc_flag clear", int'(crc_flag), 0);
        pulse_sync(); tick(2); pulse_done(); tick(2);
        chk("R11 img_loaded golden", int'(img_loaded), 2);
        chk("R11 boot_done golden", int'(boot_done), 1);
        tick(20);
        chk("R11 flags held", int'({fb_taken, wdog_flag}), 3);
        do_reset();
        chk("R11 reset clears", int'({img_loaded, fb_taken, crc_flag, wdog_flag}), 0);

        // S3: sync on the final window cycle wins
        exp_q.push_back(24'h000000);
        exp_q.push_back(24'h600000);
        feed_hdr(8'h60, 8'h00, 8'h00);
        wait_starts(2);
        tick(W - 1);
        pulse_sync(); tick(3);
        chk("R6 no fallback start", n_starts, 2);
        chk("R6 flags clear", int'({fb_taken, wdog_flag}), 0);
        pulse_done(); tick(2);
        chk("R6 primary booted", int'(img_loaded), 1);

        // S4: retry enabled, truncated image, then golden CRC failure
        do_reset();
        crc_reset_en = 1'b1;
        exp_q.push_back(24'h000000);
        exp_q.push_back(24'h600000);
        exp_q.push_back(24'h010000);
        feed_hdr(8'h60, 8'h00, 8'h00);
        wait_starts(2);
        pulse_crc();
        pulse_sync();
        tick(W + 20);
        chk("R9 early crc ignored", int'(crc_flag), 0);
        chk("R12 no watchdog after sync", int'(wdog_flag), 0);
        chk("R12 no restart after sync", n_starts, 2);
        pulse_crc();
        wait_starts(3);
        chk("R7 crc_flag", int'(crc_flag), 1);
        chk("R7 fb_taken", int'(fb_taken), 1);
        chk("R7 queue drained", exp_q.size(), 0);
        pulse_sync(); tick(2); pulse_crc(); tick(2);
        chk("R10 halted after golden crc", int'(halted), 1);
        chk("R10 done low", int'(boot_done), 0);
        chk("R10 img none", int'(img_loaded), 0);
        tick(W + 10);
        chk("R10 no further start", n_starts, 3);

        // S5: retry disabled, CRC after sync -> stuck
        do_reset();
        crc_reset_en = 1'b0;
        exp_q.push_back(24'h000000);
        exp_q.push_back(24'h600000);
        feed_hdr(8'h60, 8'h00, 8'h00);
        wait_starts(2);
        pulse_sync(); tick(3); pulse_crc();
        tick(W + 10);
        chk("R8 halted", int'(halted), 1);
        chk("R8 done low", int'(boot_done), 0);
        chk("R8 no fallback", int'(fb_taken), 0);
        chk("R8 crc_flag", int'(crc_flag), 1);
        chk("R8 no golden start", n_starts, 2);

        // S6: golden watchdog failure
        do_reset();
        exp_q.push_back(24'h000000);
        exp_q.push_back(24'h600000);
        exp_q.push_back(24'h010000);
        feed_hdr(8'h60, 8'h00, 8'h00);
        wait_starts(3);
        tick(W + 5);
        chk("R10 halted after golden wdog", int'(halted), 1);
        chk("R10 wdog_flag", int'(wdog_flag), 1);
        chk("R10 img none wdog", int'(img_loaded), 0);
        chk("R10 start count", n_starts, 3);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule